// File: doc/BRIEF.md
# Serial Flash Instruction Frame Sequencer

This block sends one serial-memory command frame over a four-line I/O bus and then stops. A frame has up to five parts, and they always run in this order: instruction byte, address, option code, dummy clocks and a data stretch. The caller turns each part on or off separately. Parts that are off produce no clock cycles. A 3-bit width code chooses how many I/O lines carry each part, so one frame can start on a single line and move to two or four lines for the address or the data.

The caller sets the frame fields and pulses `start` while the sequencer is idle. The sequencer captures every field on that strobe. It pulls chip select low, drives the serial clock, and raises `eoi` for one cycle as chip select goes high again.

Write data comes in on a byte stream. The sequencer takes a byte only in a cycle where both `wr_valid` and `wr_ready` are high. While no byte is offered, the serial clock stays low and the frame waits. Read data goes out on a second byte stream. `rd_data` stays stable while `rd_valid` is high and `rd_ready` is low. The next read byte is not clocked in until the previous one has been taken, so no data is ever lost.

Top module: `sflash_frame_seq`

## Requirements
- R1: The parts run in the order instruction, address, option, dummy, data. A part that is off adds no SCK cycle. Dummy is skipped when its count is 0, and data is skipped when `data_len` is 0.
- R2: Each width code sets the lane count for instruction, address/option and data as follows: 0→1/1/1, 1→1/1/2, 2→1/1/4, 3→1/2/2, 4→1/4/4, 5→2/2/2, 6→4/4/4. Code 7 behaves like code 0.
- R3: Every field is sent most significant bit first, with one bit group per SCK cycle. On 2 or 4 lanes, `io_out[0]` carries the lowest bit of each group. On a single lane, output uses `io_out[0]` and read input is sampled from `io_in[1]`.
- R4: `addr_long`=0 sends the low 24 bits of `addr`. `addr_long`=1 sends all 32 bits.
- R5: The option part sends the low L bits of `opt_code`, where L = 1, 2, 4 or 8 for `opt_len` = 0, 1, 2 or 3. When L is smaller than the lane count, the option takes one SCK cycle on the highest lanes and the other lanes are 0.
- R6: The dummy part lasts exactly `dummy_cycles` SCK cycles, with all output enables low.
- R7: While a part is driven, `io_oe` is 4'b0001, 4'b0011 or 4'b1111 for 1, 2 or 4 lanes. `io_oe` is 0 in idle, dummy and read data. `io_out` is 0 on every line that is not enabled.
- R8: SCK is low when idle. Each SCK cycle is one clock low followed by one clock high. Outputs change only as SCK falls, and inputs are sampled as SCK rises.
- R9: A write byte is taken when `wr_valid` and `wr_ready` are both high. `wr_ready` is high only at a byte boundary of a write data part, and SCK stays low until a byte arrives.
- R10: `rd_valid` stays high with `rd_data` stable until `rd_ready` is high. The next read byte does not begin until the buffer has been emptied.
- R11: `cs_n` is low from the cycle after `start` until the last SCK cycle of the frame ends. `eoi` is a one-cycle pulse as `cs_n` rises. When nothing is enabled, `eoi` pulses one cycle after `start` and `cs_n` never goes low.
- R12: `start` is ignored while a frame is active, and the fields captured at `start` stay in use until the frame ends.
- R13: `xfer_type[1]`=1 makes the data part a write; `xfer_type[1]`=0 makes it a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a frame (when idle) |
| width_code | input | 3 | Lane width code |
| inst_en | input | 1 | Instruction part on |
| addr_en | input | 1 | Address part on |
| opt_en | input | 1 | Option part on |
| data_en | input | 1 | Data part on |
| opt_len | input | 2 | Option length code |
| addr_long | input | 1 | 32-bit address when 1 |
| dummy_cycles | input | 5 | Dummy SCK cycles |
| xfer_type | input | 2 | Bit 1 selects write |
| inst_code | input | 8 | Instruction byte |
| addr | input | 32 | Address |
| opt_code | input | 8 | Option code |
| data_len | input | LEN_W | Data bytes in the frame |
| wr_valid | input | 1 | Write byte offered |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Write byte accepted |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | 8 | Read byte |
| rd_ready | input | 1 | Read byte taken |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| io_out | output | 4 | I/O line output values |
| io_oe | output | 4 | Per-line output enables |
| io_in | input | 4 | I/O line input values |
| eoi | output | 1 | End of frame pulse |

## Verification
The bench builds the sequencer with `LEN_W` = 8, which keeps the data length counter narrow and lets short frames of one to four bytes cover both the byte-boundary reload and the final byte. With that length, all eight width codes fit in one short run. The same run covers 1-bit and 2-bit options that are narrower than the lanes, both address lengths, and frames with no parts at all. Stalls with SCK held low are reached by gaps in the write stream and by slow read takes, and a second `start` in the middle of a frame is issued to show that the captured fields stay in use.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int FIELD_W = 32;
  localparam int BYTE_W  = 8;
  localparam int NLANE   = 4;
  localparam int DUM_W   = 5;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_INST  = 3'd1,
    PH_ADDR  = 3'd2,
    PH_OPT   = 3'd3,
    PH_DUMMY = 3'd4,
    PH_DATA  = 3'd5
  } phase_t;

  typedef struct packed {
    logic [2:0]        width;
    logic              inst_on;
    logic              addr_on;
    logic              opt_on;
    logic              data_on;
    logic [1:0]        opt_len;
    logic              addr_long;
    logic [DUM_W-1:0]  dummy;
    logic [1:0]        xfer;
    logic [BYTE_W-1:0] inst;
    logic [FIELD_W-1:0] addr;
    logic [BYTE_W-1:0] opt;
  } frame_cfg_t;

  // earliest enabled part strictly after cur; PH_IDLE when none is left
  function automatic phase_t next_phase(phase_t cur, frame_cfg_t c);
    phase_t r;
    r = PH_IDLE;
    if (cur < PH_DATA  && c.data_on)      r = PH_DATA;
    if (cur < PH_DUMMY && (c.dummy != 0)) r = PH_DUMMY;
    if (cur < PH_OPT   && c.opt_on)       r = PH_OPT;
    if (cur < PH_ADDR  && c.addr_on)      r = PH_ADDR;
    if (cur < PH_INST  && c.inst_on)      r = PH_INST;
    return r;
  endfunction
endpackage

// File: rtl/sfs_lane_dec.sv
module sfs_lane_dec
  import sfs_pkg::*;
(
  input  logic [2:0] width_code,
  input  phase_t     phase,
  output logic [1:0] lane_log
);
  always_comb begin
    lane_log = 2'd0;
    case (phase)
      PH_INST: begin
        if (width_code == 3'd5) lane_log = 2'd1;
        else if (width_code == 3'd6) lane_log = 2'd2;
      end
      PH_ADDR, PH_OPT: begin
        if (width_code == 3'd3 || width_code == 3'd5) lane_log = 2'd1;
        else if (width_code == 3'd4 || width_code == 3'd6) lane_log = 2'd2;
      end
      PH_DATA: begin
        if (width_code == 3'd1 || width_code == 3'd3 || width_code == 3'd5) lane_log = 2'd1;
        else if (width_code == 3'd2 || width_code == 3'd4 || width_code == 3'd6) lane_log = 2'd2;
      end
      default: lane_log = 2'd0;
    endcase
  end
endmodule

// File: rtl/sfs_shift.sv
module sfs_shift
  import sfs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FIELD_W-1:0] load_val,
  input  logic               shift,
  input  logic               capture,
  input  logic [1:0]         lane_log,
  input  logic [NLANE-1:0]   io_in,
  output logic [NLANE-1:0]   drive,
  output logic [BYTE_W-1:0]  rx_byte
);
  logic [FIELD_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      rx_byte <= '0;
    end else begin
      if (load)       sh <= load_val;
      else if (shift) sh <= sh << (1 << lane_log);
      if (capture) begin
        case (lane_log)
          2'd1:    rx_byte <= {rx_byte[BYTE_W-3:0], io_in[1:0]};
          2'd2:    rx_byte <= {rx_byte[BYTE_W-5:0], io_in[3:0]};
          default: rx_byte <= {rx_byte[BYTE_W-2:0], io_in[1]};
        endcase
      end
    end
  end

  always_comb begin
    case (lane_log)
      2'd1:    drive = {2'b00, sh[FIELD_W-1 -: 2]};
      2'd2:    drive = sh[FIELD_W-1 -: 4];
      default: drive = {3'b000, sh[FIELD_W-1]};
    endcase
  end

  AST_NO_LOAD_AND_CAPTURE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !shift) else $error("capture on falling slot"); // R8
endmodule

// File: rtl/sflash_frame_seq.sv
module sflash_frame_seq
  import sfs_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2:0]         width_code,
  input  logic               inst_en,
  input  logic               addr_en,
  input  logic               opt_en,
  input  logic               data_en,
  input  logic [1:0]         opt_len,
  input  logic               addr_long,
  input  logic [DUM_W-1:0]   dummy_cycles,
  input  logic [1:0]         xfer_type,
  input  logic [BYTE_W-1:0]  inst_code,
  input  logic [FIELD_W-1:0] addr,
  input  logic [BYTE_W-1:0]  opt_code,
  input  logic [LEN_W-1:0]   data_len,
  input  logic               wr_valid,
  input  logic [BYTE_W-1:0]  wr_data,
  output logic               wr_ready,
  output logic               rd_valid,
  output logic [BYTE_W-1:0]  rd_data,
  input  logic               rd_ready,
  output logic               cs_n,
  output logic               sck,
  output logic [NLANE-1:0]   io_out,
  output logic [NLANE-1:0]   io_oe,
  input  logic [NLANE-1:0]   io_in,
  output logic               eoi
);
  localparam int SLOT_W = $clog2(FIELD_W) + 1;

  phase_t             phase, nph;
  frame_cfg_t         cfg, in_cfg, src;
  logic               half, need_byte, idle, run, fall, rise;
  logic               slot_end, last_byte, take_wr, rd_push, drv_on;
  logic [SLOT_W-1:0]  slots, nslots;
  logic [LEN_W-1:0]   bytes_left;
  logic [1:0]         cur_lw, nxt_lw;
  logic [3:0]         opt_bits;
  logic [FIELD_W-1:0] ent_val, sh_val;
  logic               sh_load;
  logic [NLANE-1:0]   drive, lane_mask;
  logic [BYTE_W-1:0]  rx_byte;

  always_comb begin
    in_cfg.width     = width_code;
    in_cfg.inst_on   = inst_en;
    in_cfg.addr_on   = addr_en;
    in_cfg.opt_on    = opt_en;
    in_cfg.data_on   = data_en && (data_len != '0);
    in_cfg.opt_len   = opt_len;
    in_cfg.addr_long = addr_long;
    in_cfg.dummy     = dummy_cycles;
    in_cfg.xfer      = xfer_type;
    in_cfg.inst      = inst_code;
    in_cfg.addr      = addr;
    in_cfg.opt       = opt_code;
  end

  assign idle = (phase == PH_IDLE);
  assign src  = idle ? in_cfg : cfg;
  assign nph  = next_phase(phase, src);

  sfs_lane_dec u_dec_cur (.width_code(cfg.width), .phase(phase), .lane_log(cur_lw));
  sfs_lane_dec u_dec_nxt (.width_code(src.width), .phase(nph),   .lane_log(nxt_lw));

  // field image and slot count of the part about to begin
  always_comb begin
    opt_bits = 4'd1 << src.opt_len;
    ent_val  = '0;
    nslots   = '0;
    case (nph)
      PH_INST: begin
        ent_val = {src.inst, {(FIELD_W-BYTE_W){1'b0}}};
        nslots  = SLOT_W'(BYTE_W >> nxt_lw);
      end
      PH_ADDR: begin
        ent_val = src.addr_long ? src.addr : {src.addr[23:0], 8'h00};
        nslots  = src.addr_long ? SLOT_W'(32 >> nxt_lw) : SLOT_W'(24 >> nxt_lw);
      end
      PH_OPT: begin
        ent_val = {src.opt, {(FIELD_W-BYTE_W){1'b0}}} << (4'd8 - opt_bits);
        nslots  = (opt_bits > (4'd1 << nxt_lw)) ? SLOT_W'(opt_bits >> nxt_lw) : SLOT_W'(1);
      end
      PH_DUMMY: nslots = SLOT_W'(src.dummy);
      PH_DATA:  nslots = SLOT_W'(BYTE_W >> nxt_lw);
      default:  nslots = '0;
    endcase
  end

  assign run       = !idle && !need_byte;
  assign rise      = run && !half;
  assign fall      = run && half;
  assign slot_end  = fall && (slots == SLOT_W'(1));
  assign last_byte = (bytes_left == LEN_W'(1));
  assign wr_ready  = (phase == PH_DATA) && need_byte && cfg.xfer[1];
  assign take_wr   = wr_valid && wr_ready;
  assign rd_push   = slot_end && (phase == PH_DATA) && !cfg.xfer[1];

  assign sh_load = (idle && start && nph != PH_IDLE) ||
                   (slot_end && !(phase == PH_DATA && !last_byte) && nph != PH_IDLE) ||
                   take_wr;
  assign sh_val  = take_wr ? {wr_data, {(FIELD_W-BYTE_W){1'b0}}} : ent_val;

  sfs_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val), .shift(fall),
    .capture(rise && phase == PH_DATA && !cfg.xfer[1]), .lane_log(cur_lw),
    .io_in(io_in), .drive(drive), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      cfg        <= '0;
      half       <= 1'b0;
      need_byte  <= 1'b0;
      slots      <= '0;
      bytes_left <= '0;
      eoi        <= 1'b0;
    end else begin
      eoi <= 1'b0;
      if (idle) begin
        if (start) begin
          cfg        <= in_cfg;
          bytes_left <= data_len;
          if (nph == PH_IDLE) eoi <= 1'b1;
          else begin
            phase     <= nph;
            slots     <= nslots;
            need_byte <= (nph == PH_DATA);
          end
        end
      end else if (need_byte) begin
        if (cfg.xfer[1] ? wr_valid : !rd_valid) need_byte <= 1'b0;
      end else if (!half) begin
        half <= 1'b1;
      end else begin
        half <= 1'b0;
        if (slots != SLOT_W'(1)) slots <= slots - SLOT_W'(1);
        else if (phase == PH_DATA && !last_byte) begin
          bytes_left <= bytes_left - LEN_W'(1);
          slots      <= SLOT_W'(BYTE_W >> cur_lw);
          need_byte  <= 1'b1;
        end else begin
          phase     <= nph;
          slots     <= nslots;
          need_byte <= (nph == PH_DATA);
          if (nph == PH_IDLE) eoi <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (rd_push) begin
      rd_valid <= 1'b1;
      rd_data  <= rx_byte;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  always_comb begin
    case (cur_lw)
      2'd1:    lane_mask = 4'b0011;
      2'd2:    lane_mask = 4'b1111;
      default: lane_mask = 4'b0001;
    endcase
  end

  assign drv_on = (phase == PH_INST) || (phase == PH_ADDR) || (phase == PH_OPT) ||
                  ((phase == PH_DATA) && cfg.xfer[1]);
  assign io_oe  = drv_on ? lane_mask : '0;
  assign io_out = drive & io_oe;
  assign cs_n   = idle;
  assign sck    = half;

  AST_SCK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck) else $error("sck high outside frame"); // R8
  AST_SCK_ONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |=> $fell(sck)) else $error("sck high too long"); // R8
  AST_EOI_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> !eoi) else $error("eoi longer than one cycle"); // R11
  AST_EOI_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |-> cs_n) else $error("eoi with cs low"); // R11
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == '0)) else $error("drive while idle"); // R7
  AST_WR_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!sck && !cs_n)) else $error("wr_ready off boundary"); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))) else $error("read byte dropped"); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && start) |=> $stable(cfg)) else $error("config changed mid frame"); // R12
endmodule

// File: tb/sflash_frame_seq_tb.sv
module sflash_frame_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] width_code = '0;
  logic inst_en = 0, addr_en = 0, opt_en = 0, data_en = 0, addr_long = 0;
  logic [1:0] opt_len = '0, xfer_type = '0;
  logic [4:0] dummy_cycles = '0;
  logic [7:0] inst_code = '0, opt_code = '0, wr_data = '0;
  logic [31:0] addr = '0;
  logic [LEN_W-1:0] data_len = '0;
  logic wr_valid = 0, wr_ready, rd_valid, rd_ready = 0, cs_n, sck, eoi;
  logic [7:0] rd_data;
  logic [3:0] io_out, io_oe, io_in = '0;

  typedef struct { logic [3:0] oe; logic [3:0] out; logic [3:0] drv; } slot_t;
  slot_t exp_q[$];
  logic [7:0] rd_q[$];
  logic [7:0] wr_src[$];
  int errors = 0, checks = 0, eoi_cnt = 0, cs_low_cnt = 0, cyc = 0;
  bit wr_gap = 0, rd_stall = 0, wr_taken = 0, sck_prev = 0, done = 0;

  sflash_frame_seq #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .width_code(width_code),
    .inst_en(inst_en), .addr_en(addr_en), .opt_en(opt_en), .data_en(data_en),
    .opt_len(opt_len), .addr_long(addr_long), .dummy_cycles(dummy_cycles),
    .xfer_type(xfer_type), .inst_code(inst_code), .addr(addr), .opt_code(opt_code),
    .data_len(data_len), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready), .cs_n(cs_n),
    .sck(sck), .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .eoi(eoi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // lanes per part from the R2 table; part 0 = instruction, 1 = address/option, 2 = data
  function automatic int lanes(input int code, input int part);
    case (code)
      1: return (part == 2) ? 2 : 1;
      2: return (part == 2) ? 4 : 1;
      3: return (part == 0) ? 1 : 2;
      4: return (part == 0) ? 1 : 4;
      5: return 2;
      6: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic logic [3:0] mask_of(input int w);
    return (w == 1) ? 4'b0001 : (w == 2) ? 4'b0011 : 4'b1111;
  endfunction

  // R3: MSB first, lowest lane = lowest bit of group; single-lane reads on io_in[1]
  task automatic push_bits(input logic [31:0] left, input int nbits, input int w, input bit rd);
    int n;
    logic [31:0] s;
    logic [3:0] g;
    slot_t it;
    n = (nbits >= w) ? nbits / w : 1;
    s = left;
    for (int i = 0; i < n; i++) begin
      g = 4'(s >> (32 - w));
      s = s << w;
      if (!rd) begin it.oe = mask_of(w); it.out = g; it.drv = 4'h0; end
      else begin it.oe = 4'h0; it.out = 4'h0; it.drv = (w == 1) ? {2'b00, g[0], 1'b0} : g; end
      exp_q.push_back(it);
    end
  endtask

  // scoreboard monitor: one expected slot per SCK rise
  always @(negedge clk) begin
    slot_t it;
    cyc++;
    if (!cs_n) cs_low_cnt++;
    if (eoi) eoi_cnt++;
    if (rst_n && sck && !sck_prev) begin
      if (exp_q.size() == 0) chk(0, "R1", "unexpected SCK cycle", 1, 0);
      else begin
        it = exp_q.pop_front();
        chk(io_oe == it.oe, "R7", "io_oe", io_oe, it.oe);
        chk(io_out == it.out, "R3", "io_out", io_out, it.out);
        chk(!cs_n, "R11", "cs_n during SCK", cs_n, 0);
      end
      io_in = (exp_q.size() > 0) ? exp_q[0].drv : 4'h0;
    end
    sck_prev = sck;
  end

  // read consumer (R10)
  always @(negedge clk) begin
    rd_ready = rd_stall ? (cyc % 5 == 0) : 1'b1;
    if (rd_valid && rd_ready) begin
      if (rd_q.size() == 0) chk(0, "R10", "extra read byte", rd_data, 0);
      else chk(rd_data == rd_q[0], "R10", "read byte", rd_data, rd_q[0]);
      if (rd_q.size() > 0) void'(rd_q.pop_front());
    end
  end

  // write feeder (R9)
  always @(negedge clk) begin
    if (wr_taken) begin
      void'(wr_src.pop_front());
      wr_taken = 0;
    end
    wr_valid = (wr_src.size() > 0) && !(wr_gap && (cyc % 4 != 0));
    wr_data  = (wr_src.size() > 0) ? wr_src[0] : 8'h00;
    if (wr_valid && wr_ready) wr_taken = 1;
  end

  task automatic run_frame(input string req, input int code, input bit ie, input bit ae,
                           input bit oe_, input bit de, input int ol, input bit al,
                           input int nd, input bit wr, input logic [7:0] ic,
                           input logic [31:0] ad, input logic [7:0] oc, input int len,
                           input bit wgap, input bit rstall, input int restart_at);
    int e0, t, L;
    logic [7:0] b;
    L = 1 << ol;
    if (ie) push_bits({ic, 24'h0}, 8, lanes(code, 0), 0);
    if (ae) push_bits(al ? ad : {ad[23:0], 8'h00}, al ? 32 : 24, lanes(code, 1), 0);
    if (oe_) push_bits(32'(oc) << (32 - L), L, lanes(code, 1), 0);
    for (int i = 0; i < nd; i++) push_bits(32'h0, 1, 1, 1);
    if (de) for (int k = 0; k < len; k++) begin
      b = 8'(8'h3C + k * 81 + code * 17);
      push_bits({b, 24'h0}, 8, lanes(code, 2), !wr);
      if (wr) wr_src.push_back(b); else rd_q.push_back(b);
    end
    wr_gap = wgap; rd_stall = rstall;
    @(negedge clk);
    io_in = (exp_q.size() > 0) ? exp_q[0].drv : 4'h0;
    width_code = 3'(code); inst_en = ie; addr_en = ae; opt_en = oe_; data_en = de;
    opt_len = 2'(ol); addr_long = al; dummy_cycles = 5'(nd); xfer_type = wr ? 2'b10 : 2'b00;
    inst_code = ic; addr = ad; opt_code = oc; data_len = LEN_W'(len);
    e0 = eoi_cnt;
    start = 1;
    @(negedge clk);
    start = 0;
    t = 0;
    while (eoi_cnt == e0 && t < 4000) begin
      @(negedge clk);
      t++;
      if (restart_at > 0 && t == restart_at) begin   // R12 second start mid frame
        start = 1; width_code = 3'd6; inst_code = ~ic; data_len = LEN_W'(1);
      end else if (restart_at > 0 && t == restart_at + 1) begin
        start = 0; width_code = 3'(code); inst_code = ic; data_len = LEN_W'(len);
      end
    end
    chk(eoi_cnt == e0 + 1, "R11", {req, " eoi count"}, eoi_cnt - e0, 1);
    chk(exp_q.size() == 0, "R1", {req, " missing SCK cycles"}, exp_q.size(), 0);
    chk(cs_n == 1'b1, "R11", {req, " cs_n after frame"}, cs_n, 1);
    t = 0;
    while ((rd_q.size() > 0 || wr_src.size() > 0) && t < 2000) begin @(negedge clk); t++; end
    chk(rd_q.size() == 0, "R10", {req, " read bytes left"}, rd_q.size(), 0);
    chk(wr_src.size() == 0, "R9", {req, " write bytes left"}, wr_src.size(), 0);
    exp_q.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int cl0, e0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1 && sck == 0, "R8", "reset cs_n/sck", {cs_n, sck}, 2'b10);
    chk(io_oe == 0 && eoi == 0, "R7", "reset io_oe/eoi", {io_oe, eoi}, 0);
    chk(wr_ready == 0 && rd_valid == 0, "R9", "reset streams", {wr_ready, rd_valid}, 0);
    // R2 R4 R13 single-lane write, 24-bit address
    run_frame("R2 code0 write", 0, 1, 1, 0, 1, 0, 0, 0, 1, 8'h9F, 32'hAB123456, 8'h00, 2, 0, 0, 0);
    // R5 R6 R10 quad, 32-bit address, 8-bit option, dummy, slow reads
    run_frame("R5 code6 read", 6, 1, 1, 1, 1, 3, 1, 4, 0, 8'hEB, 32'hDEADBEEF, 8'hA5, 3, 0, 1, 0);
    // R5 1-bit option on 2 lanes, R6 dummy, dual read
    run_frame("R5 code3 opt1", 3, 1, 1, 1, 1, 0, 0, 2, 0, 8'hBB, 32'h00C0FFEE, 8'h01, 2, 0, 0, 0);
    // R9 write gaps, dual data
    run_frame("R9 code1 gaps", 1, 1, 1, 0, 1, 0, 0, 0, 1, 8'hA2, 32'h00010203, 8'h00, 4, 1, 0, 0);
    // R5 2-bit option on 4 lanes, instruction off
    run_frame("R5 code4 opt2", 4, 0, 1, 1, 1, 1, 1, 1, 0, 8'h00, 32'h89ABCDEF, 8'h06, 2, 0, 0, 0);
    run_frame("R2 code5 write", 5, 1, 1, 1, 1, 2, 0, 0, 1, 8'h5A, 32'h00777777, 8'h0C, 1, 0, 0, 0);
    run_frame("R2 code2 read", 2, 1, 1, 0, 1, 0, 0, 3, 0, 8'h6B, 32'h00112233, 8'h00, 2, 0, 1, 0);
    run_frame("R2 code7 as 0", 7, 1, 0, 0, 1, 0, 0, 0, 0, 8'h03, 32'h0, 8'h00, 1, 0, 0, 0);
    run_frame("R6 dummy only", 6, 0, 0, 0, 0, 0, 0, 3, 0, 8'h00, 32'h0, 8'h00, 0, 0, 0, 0);
    run_frame("R1 zero length", 0, 1, 0, 0, 1, 0, 0, 0, 1, 8'h06, 32'h0, 8'h00, 0, 0, 0, 0);
    run_frame("R12 restart", 0, 1, 1, 0, 1, 0, 0, 0, 1, 8'h32, 32'h00445566, 8'h00, 2, 0, 0, 6);
    // R1 R11 nothing enabled: eoi one cycle after start, no SCK, cs never low
    cl0 = cs_low_cnt; e0 = eoi_cnt;
    @(negedge clk);
    inst_en = 0; addr_en = 0; opt_en = 0; data_en = 0; dummy_cycles = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(eoi == 1'b1, "R11", "empty frame eoi", eoi, 1);
    repeat (4) @(negedge clk);
    chk(eoi_cnt == e0 + 1, "R11", "empty frame eoi count", eoi_cnt - e0, 1);
    chk(cs_low_cnt == cl0, "R1", "empty frame cs low cycles", cs_low_cnt - cl0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule